// File: doc/BRIEF.md
# Serial Master Readout Engine for a Successive-Approximation Converter

This block sits on the digital side of a successive-approximation converter and sends each conversion result to a host over a three-wire serial link where the block is the master. It makes its own bit clock (`sclk`) and a frame strobe (`sync`) that is active while a word is on the line. Each of these two outputs can be inverted with its own control bit. A host, or a sequencer, raises `conv_start` to start a conversion. The converter core signals the end of the conversion with a one-cycle `conv_done` pulse that carries the result on `conv_result`. The result is captured into a shift register at that moment, so a later conversion cannot disturb a word that is still being sent.

Two read timings are available. In read-after mode (`rd_during` = 0) the new result is shifted out as soon as its conversion ends, and `busy` stays high until the last bit has gone. A two-bit divide select can slow the bit clock in this mode. In read-during mode (`rd_during` = 1) `busy` drops when the conversion ends, and the captured word is held. It is shifted out at the base rate while the next conversion runs. This keeps serial activity away from the end of the conversion, so this is the high-throughput mode.

A bit lasts four quarters of Q system clocks. `sclk` (before inversion) is high in the middle two quarters. `sdout` changes only at the boundary from the fourth quarter to the first, which keeps it stable across both clock edges.

Top module: `ser_readout_master`

## Requirements
- R1: Each frame carries exactly W = 18 bits, most significant bit first, with one rising edge of the uninverted `sclk` per bit. The frame strobe is active for the whole frame.
- R2: A bit lasts 4·Q clock cycles. The uninverted `sclk` is low in quarters 0 and 3 and high in quarters 1 and 2. `sdout` changes only between quarter 3 of one bit and quarter 0 of the next. A frame therefore lasts 72·Q cycles.
- R3: In read-after mode the frame starts in the cycle after the `conv_done` pulse, and `busy` stays high until the frame ends. `busy` is low from the cycle after the last frame cycle.
- R4: In read-after mode, `div_sel` sampled with `conv_done` sets Q = BASE_Q·{1,2,4,8} for the codes 00, 01, 10 and 11. In read-during mode `div_sel` has no effect and Q = BASE_Q.
- R5: In read-during mode `busy` is low in the cycle after `conv_done`, and the result is held. It is shifted out starting in the cycle after the next accepted `conv_start`.
- R6: `conv_start` is accepted only when `busy` is low and no frame is active. A start that is refused leaves `busy` low.
- R7: A `conv_done` pulse with no conversion in progress has no effect. A result that arrives while a frame is active is dropped, and the frame in flight completes with its own word.
- R8: `sclk_inv` = 1 inverts `sclk`, and `sync_inv` = 1 inverts `sync`. The inverted outputs include their idle levels.
- R9: With `ext_clk_sel` = 1 the block does not drive its master outputs: `sclk` and `sync` sit at their idle levels and `sdout` is low. Conversion and `busy` sequencing continue unchanged.
- R10: When idle, `sclk` equals `sclk_inv`, `sync` equals `sync_inv`, and `sdout` is low.
- R11: Synchronous active-high `rst` drops `busy` and `sync`, stops any frame, and discards a held word, so the first start after reset sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_sel | input | 1 | 1 disables the master outputs |
| rd_during | input | 1 | 1 selects read-during mode, 0 selects read-after mode |
| sclk_inv | input | 1 | Inverts `sclk` |
| sync_inv | input | 1 | Inverts `sync` |
| div_sel | input | 2 | Bit clock divide select (read-after mode only) |
| conv_start | input | 1 | Conversion start request |
| conv_done | input | 1 | One-cycle conversion end pulse |
| conv_result | input | 18 | Result, valid with `conv_done` |
| sclk | output | 1 | Serial bit clock |
| sdout | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame valid strobe |
| busy | output | 1 | Conversion (and read-after frame) in progress |

## Verification
Words with alternating, sparse and all-ones bit patterns are sent in read-after mode under every divide code. This separates bit-order and shift errors from wrong quarter lengths. The same patterns in read-during mode, sent with the slowest divide code selected, show whether the divider is wrongly applied to that mode. A held word is also checked to come from the previous conversion and not the current one. Starts during a frame, stray and overlapping `conv_done` pulses, and reset with a word held test the ignore and discard rules. Runs with inverted polarity and with the master outputs disabled show that only the pins change and the sequencing does not.

// File: rtl/sro_pkg.sv
package sro_pkg;

  typedef logic [1:0] div_t;

  // System clocks per quarter bit for a given base and divide code.
  function automatic int unsigned quarter_len(input int unsigned base, input div_t code);
    return base << code;
  endfunction

  // Cycles in one whole frame.
  function automatic int unsigned frame_len(input int unsigned base, input div_t code,
                                            input int unsigned nbits);
    return 4 * nbits * quarter_len(base, code);
  endfunction

endpackage

// File: rtl/sro_shifter.sv
module sro_shifter
  import sro_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter int unsigned BASE_Q = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] word,
  input  logic         go,
  input  div_t         go_div,
  output logic         act,
  output logic         done_p,
  output logic         sclk_raw,
  output logic         sdout_raw
);
  localparam int unsigned BW = $clog2(W);
  localparam int unsigned TW = $clog2(BASE_Q * 8 + 1);

  logic [W-1:0]  sh;
  logic [BW-1:0] bitc;
  logic [1:0]    qc;
  logic [TW-1:0] tc;
  div_t          div_q;
  logic          act_q;
  logic [TW-1:0] qmax;
  logic          tick;

  assign qmax   = TW'(quarter_len(BASE_Q, div_q) - 1);
  assign tick   = act_q && (tc == qmax);
  assign done_p = tick && (qc == 2'd3) && (bitc == BW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      bitc  <= '0;
      qc    <= '0;
      tc    <= '0;
      div_q <= '0;
      sh    <= '0;
    end else begin
      if (ld) sh <= word;
      if (go) begin
        act_q <= 1'b1;
        bitc  <= '0;
        qc    <= '0;
        tc    <= '0;
        div_q <= go_div;
      end else if (tick) begin
        tc <= '0;
        qc <= qc + 2'd1;
        if (qc == 2'd3) begin
          bitc <= bitc + BW'(1);
          sh   <= {sh[W-2:0], 1'b0};
        end
        if (done_p) act_q <= 1'b0;
      end else if (act_q) begin
        tc <= tc + TW'(1);
      end
    end
  end

  assign act       = act_q;
  assign sclk_raw  = act_q && ((qc == 2'd1) || (qc == 2'd2));
  assign sdout_raw = act_q && sh[W-1];

endmodule

// File: rtl/sro_ctrl.sv
module sro_ctrl
  import sro_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic conv_start,
  input  logic conv_done,
  input  logic rd_during,
  input  div_t div_sel,
  input  logic act,
  input  logic done_p,
  output logic busy,
  output logic conv_act,
  output logic hold_busy,
  output logic accept_start,
  output logic done_evt,
  output logic ld,
  output logic go,
  output div_t go_div
);
  logic busy_q, conv_q, pend_q, hold_q;
  logic go_after, go_during;

  assign accept_start = conv_start && !busy_q && !act;
  assign done_evt     = conv_done && conv_q;
  assign ld           = done_evt && !act;
  assign go_after     = ld && !rd_during;
  assign go_during    = accept_start && rd_during && pend_q;
  assign go           = go_after || go_during;
  assign go_div       = go_after ? div_sel : div_t'(0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      conv_q <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (accept_start)                         busy_q <= 1'b1;
      else if (done_evt && (rd_during || act))  busy_q <= 1'b0;
      else if (done_p && hold_q)                busy_q <= 1'b0;

      if (accept_start)  conv_q <= 1'b1;
      else if (done_evt) conv_q <= 1'b0;

      if (ld)             pend_q <= rd_during;
      else if (go_during) pend_q <= 1'b0;

      if (go) hold_q <= go_after;
    end
  end

  assign busy      = busy_q;
  assign conv_act  = conv_q;
  assign hold_busy = hold_q;

endmodule

// File: rtl/sro_pins.sv
module sro_pins (
  input  logic ext_clk_sel,
  input  logic sclk_inv,
  input  logic sync_inv,
  input  logic sclk_raw,
  input  logic frame_raw,
  input  logic sdout_raw,
  output logic sclk,
  output logic sync,
  output logic sdout
);
  logic drive_en;
  assign drive_en = !ext_clk_sel;
  assign sclk  = (sclk_raw  && drive_en) ^ sclk_inv;
  assign sync  = (frame_raw && drive_en) ^ sync_inv;
  assign sdout = sdout_raw && drive_en;
endmodule

// File: rtl/ser_readout_master.sv
module ser_readout_master
  import sro_pkg::*;
#(
  parameter int unsigned W      = 18,
  parameter int unsigned BASE_Q = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_clk_sel,
  input  logic         rd_during,
  input  logic         sclk_inv,
  input  logic         sync_inv,
  input  logic [1:0]   div_sel,
  input  logic         conv_start,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  output logic         sclk,
  output logic         sdout,
  output logic         sync,
  output logic         busy
);
  logic act, done_p, sclk_raw, sdout_raw;
  logic conv_act, hold_busy, accept_start, done_evt, ld, go;
  div_t go_div;

  sro_ctrl u_ctrl (
    .clk(clk), .rst(rst), .conv_start(conv_start), .conv_done(conv_done),
    .rd_during(rd_during), .div_sel(div_sel), .act(act), .done_p(done_p),
    .busy(busy), .conv_act(conv_act), .hold_busy(hold_busy),
    .accept_start(accept_start), .done_evt(done_evt), .ld(ld), .go(go),
    .go_div(go_div)
  );

  sro_shifter #(.W(W), .BASE_Q(BASE_Q)) u_shift (
    .clk(clk), .rst(rst), .ld(ld), .word(conv_result), .go(go),
    .go_div(go_div), .act(act), .done_p(done_p), .sclk_raw(sclk_raw),
    .sdout_raw(sdout_raw)
  );

  sro_pins u_pins (
    .ext_clk_sel(ext_clk_sel), .sclk_inv(sclk_inv), .sync_inv(sync_inv),
    .sclk_raw(sclk_raw), .frame_raw(act), .sdout_raw(sdout_raw),
    .sclk(sclk), .sync(sync), .sdout(sdout)
  );

endmodule

// File: rtl/sro_checker.sv
module sro_checker #(
  parameter int unsigned W = 18
) (
  input logic clk,
  input logic rst,
  input logic conv_done,
  input logic rd_during,
  input logic conv_act,
  input logic busy,
  input logic hold_busy,
  input logic act,
  input logic go,
  input logic done_p,
  input logic sclk_raw,
  input logic sdout_raw
);
  localparam int unsigned CW = $clog2(W + 1) + 1;
  logic [CW-1:0] rises;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rises  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_raw;
      if (go) rises <= '0;
      else if (sclk_raw && !sclk_d) rises <= rises + CW'(1);
    end
  end

  // R1: eighteen clock rises per frame
  a_r1_pulse_count: assert property (@(posedge clk) disable iff (rst)
    done_p |-> (rises == CW'(W)));

  // R2: data stable across each clock edge
  a_r2_edge_stable: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk_raw) || $fell(sclk_raw)) |-> $stable(sdout_raw));

  // R2: data held while the clock is high
  a_r2_high_hold: assert property (@(posedge clk) disable iff (rst)
    (sclk_raw && $past(sclk_raw)) |-> $stable(sdout_raw));

  // R3: busy held over a read-after frame
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (act && hold_busy) |-> busy);

  // R5: busy drops after conversion end in read-during mode
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_act && rd_during) |=> !busy);

  // R6: a frame never restarts over an active one
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    go |-> !act);

  // R10: idle data line is low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!act && $past(!act)) |-> !sdout_raw);

endmodule

bind ser_readout_master sro_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .conv_done(conv_done), .rd_during(rd_during),
  .conv_act(conv_act), .busy(busy), .hold_busy(hold_busy), .act(act),
  .go(go), .done_p(done_p), .sclk_raw(sclk_raw), .sdout_raw(sdout_raw)
);

// File: tb/sim_ser_readout_master.sv
`timescale 1ns/1ps
module sim_ser_readout_master;
  localparam int W = 18;
  localparam int BQ = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_clk_sel = 1'b0, rd_during = 1'b0, sclk_inv = 1'b0, sync_inv = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic conv_start = 1'b0, conv_done = 1'b0;
  logic [W-1:0] conv_result = '0;
  logic sclk, sdout, sync, busy;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ser_readout_master #(.W(W), .BASE_Q(BQ)) u0 (
    .clk(clk), .rst(rst), .ext_clk_sel(ext_clk_sel), .rd_during(rd_during),
    .sclk_inv(sclk_inv), .sync_inv(sync_inv), .div_sel(div_sel),
    .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result),
    .sclk(sclk), .sdout(sdout), .sync(sync), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  // Behavioural reference: frame time counter, flags
  bit m_busy, m_conv, m_shift, m_after, m_pend;
  int m_t, m_q;
  logic [W-1:0] m_word, m_pword;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_conv = 0; m_shift = 0; m_after = 0; m_pend = 0; m_t = 0; m_q = BQ;
    end else begin
      bit was_shift, st_ok, dn_ok;
      was_shift = m_shift;
      st_ok = conv_start && !m_busy && !m_shift;
      dn_ok = conv_done && m_conv;
      if (m_shift) begin
        if (m_t == 4 * W * m_q - 1) begin
          m_shift = 0;
          if (m_after) m_busy = 0;
        end else m_t++;
      end
      if (st_ok) begin
        m_busy = 1; m_conv = 1;
        if (rd_during && m_pend) begin
          m_shift = 1; m_t = 0; m_q = BQ; m_after = 0; m_pend = 0; m_word = m_pword;
        end
      end
      if (dn_ok) begin
        m_conv = 0;
        if (rd_during || was_shift) m_busy = 0;
        if (!was_shift) begin
          if (rd_during) begin
            m_pend = 1; m_pword = conv_result;
          end else begin
            m_pend = 0; m_shift = 1; m_t = 0; m_after = 1;
            m_q = BQ * (1 << div_sel); m_word = conv_result;
          end
        end
      end
    end
  end

  // Per-cycle compare and frame monitor
  bit prev_s, prev_k;
  int flen, fpul, fr_cnt, fr_len, fr_pul;
  logic [W-1:0] fbits, fr_word;

  always @(posedge clk) begin
    #2;
    if (!rst) begin
      bit ek, es, ed, en, rk, rs;
      int q4;
      q4 = (m_t / m_q) % 4;
      en = !ext_clk_sel;
      ek = ((m_shift && (q4 == 1 || q4 == 2)) && en) ^ sclk_inv;
      es = (m_shift && en) ^ sync_inv;
      ed = m_shift && en && m_word[W - 1 - m_t / (4 * m_q)];
      chk(sclk === ek, "R2 sclk cycle", sclk, ek);
      chk(sdout === ed, "R1 sdout cycle", sdout, ed);
      chk(sync === es, "R8 sync cycle", sync, es);
      chk(busy === m_busy, "R3 busy cycle", busy, m_busy);
      rs = sync ^ sync_inv;
      rk = sclk ^ sclk_inv;
      if (rs && !prev_s) begin flen = 0; fpul = 0; fbits = '0; end
      if (rs) flen++;
      if (rs && rk && !prev_k) begin fbits = {fbits[W-2:0], sdout}; fpul++; end
      if (!rs && prev_s) begin fr_len = flen; fr_pul = fpul; fr_word = fbits; fr_cnt++; end
      prev_s = rs; prev_k = rk;
    end
  end

  task automatic do_start();
    @(negedge clk) conv_start = 1'b1;
    @(negedge clk) conv_start = 1'b0;
  endtask

  task automatic do_done(input logic [W-1:0] w);
    @(negedge clk) begin conv_done = 1'b1; conv_result = w; end
    @(negedge clk) conv_done = 1'b0;
  endtask

  task automatic wait_frame(input int n);
    for (int i = 0; i < 4000 && fr_cnt < n; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input logic [W-1:0] w, input int len);
    chk(fr_word == w, {tag, " word"}, fr_word, w);
    chk(fr_pul == W, "R1 pulses", fr_pul, W);
    chk(fr_len == len, {tag, " length"}, fr_len, len);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int nf;
    logic [W-1:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R10 reset and idle state
    chk(busy == 0, "R11 busy after reset", busy, 0);
    chk(sync == 0 && sclk == 0 && sdout == 0, "R10 idle pins", {sync, sclk, sdout}, 0);

    // R3 read-after, divide 00
    do_start();
    repeat (3) @(negedge clk);
    chk(busy == 1, "R3 busy during conversion", busy, 1);
    do_done(18'h2B5C3);
    chk(sync == 1, "R3 frame starts next cycle", sync, 1);
    chk(sdout == 1, "R1 msb first", sdout, 1);
    repeat (4 * W - 1) @(negedge clk);
    chk(busy == 1, "R3 busy on last frame cycle", busy, 1);
    @(negedge clk);
    chk(busy == 0, "R3 busy after frame", busy, 0);
    wait_frame(1);
    check_frame("R2", 18'h2B5C3, 4 * W);

    // R4 every divide code
    for (int d = 1; d < 4; d++) begin
      nf = fr_cnt + 1;
      div_sel = 2'(d);
      w = (d == 1) ? 18'h15555 : (d == 2) ? 18'h00081 : 18'h3FFFF;
      do_start();
      do_done(w);
      wait_frame(nf);
      check_frame("R4", w, 4 * W * (1 << d));
    end

    // R5 read-during, divide ignored
    rd_during = 1'b1;
    div_sel = 2'd3;
    do_start();
    do_done(18'h0F0F1);
    chk(busy == 0, "R5 busy drops at conversion end", busy, 0);
    chk(sync == 0, "R5 no frame at conversion end", sync, 0);
    nf = fr_cnt + 1;
    do_start();
    chk(sync == 1, "R5 frame starts after start", sync, 1);
    wait_frame(nf);
    check_frame("R4 read-during", 18'h0F0F1, 4 * W);
    do_done(18'h3A5A5);

    // R6 / R7 overlap during a frame
    nf = fr_cnt + 1;
    do_start();
    repeat (2) @(negedge clk);
    do_done(18'h11111);
    chk(busy == 0, "R7 busy drops on overlapping result", busy, 0);
    do_start();
    chk(busy == 0, "R6 start during frame ignored", busy, 0);
    wait_frame(nf);
    check_frame("R7 frame in flight", 18'h3A5A5, 4 * W);
    do_start();
    repeat (6) @(negedge clk);
    chk(sync == 0, "R7 dropped result not sent", sync, 0);
    do_done(18'h22222);

    // R7 stray done
    rd_during = 1'b0;
    nf = fr_cnt;
    do_done(18'h33333);
    repeat (3) @(negedge clk);
    chk(busy == 0 && sync == 0, "R7 stray done ignored", {busy, sync}, 0);
    chk(fr_cnt == nf, "R7 no frame from stray done", fr_cnt, nf);

    // R8 inversion
    div_sel = 2'd0;
    sclk_inv = 1'b1; sync_inv = 1'b1;
    @(negedge clk);
    chk(sclk == 1 && sync == 1 && sdout == 0, "R8 inverted idle", {sclk, sync, sdout}, 6);
    nf = fr_cnt + 1;
    do_start();
    do_done(18'h2C3D4);
    wait_frame(nf);
    check_frame("R8", 18'h2C3D4, 4 * W);

    // R9 master outputs disabled
    ext_clk_sel = 1'b1;
    nf = fr_cnt;
    do_start();
    do_done(18'h3FFFF);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(sclk == 1 && sync == 1 && sdout == 0, "R9 outputs at rest",
          {sclk, sync, sdout}, 6);
    end
    chk(busy == 1, "R9 sequencing continues", busy, 1);
    repeat (60) @(negedge clk);
    chk(busy == 0 && fr_cnt == nf, "R9 busy released", {busy, 8'(fr_cnt - nf)}, 0);
    ext_clk_sel = 1'b0; sclk_inv = 1'b0; sync_inv = 1'b0;

    // R11 reset discards held word
    rd_during = 1'b1;
    do_start();
    do_done(18'h12345);
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && sync == 0, "R11 cleared by reset", {busy, sync}, 0);
    do_start();
    repeat (5) @(negedge clk);
    chk(sync == 0, "R11 held word discarded", sync, 0);
    do_done(18'h0);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule